// File: doc/BRIEF.md
# Core-Local Prioritized Interrupt Controller

This block sits beside one processor core. It gathers a parameterized number of interrupt request lines and presents a single selected request to the core. Each source has a small register word holding its pending flag, an enable, a trigger mode and a control byte. A global configuration register decides how the effective bits of each control byte divide into an interrupt level (upper bits) and a priority (lower bits). A threshold register masks low-level work. Enabled, pending sources are ranked by level, then priority, then source number. When the winner's level is above both the threshold and the level currently being serviced, the controller raises a request carrying the winner's ID and level.

The core answers with an acknowledge pulse when it enters a handler and a done pulse when the handler exits. The controller keeps a stack of in-service levels. An acknowledge pushes the accepted level, which allows a higher level to preempt and nest. A done pops it, so the interrupted handler's level comes back. When a done arrives while work that outranks the restored level is already waiting, the controller flags a tail-chain in that same cycle. The core can then pass straight to the waiting handler without first returning to the preempted context. The register port is a plain single-cycle read/write bus with combinational read data. The reset input is expected to be already synchronized on release.

Top module: `core_irq_ctrl`

## Requirements
- R1: Source `n` occupies word address `2**ID_W + n`. In that word, bit 0 is pending, bit 1 is enable, bits 3:2 are the trigger mode and bits 15:8 are the control byte. Only the top `CTL_BITS` bits of the control byte are stored; the bits below them always read as ones.
- R2: Trigger mode 0 makes pending follow the synchronized input while it is high, and mode 3 while it is low. In these two modes a bus write to the pending bit has no effect.
- R3: Mode 1 (rising) and mode 2 (falling) latch pending on that edge of the synchronized input. Pending clears when the core acknowledges that source's ID, and a bus write to bit 0 sets or clears it.
- R4: Global word 0, bits 3:0, holds the level-bit count. A written value above `CTL_BITS` is stored as `CTL_BITS`. The level equals the control byte with every bit below the top level-bit count forced to one, so a count of 0 gives level 255 to every source.
- R5: Global word 1 is read-only. It reads version in bits 7:0, the source count in bits 20:8 and `CTL_BITS` in bits 24:21, and writes to it are ignored.
- R6: Among enabled, pending sources, the one with the largest control byte wins, which means highest level first and then highest priority. Remaining ties go to the larger source ID.
- R7: Global word 2, bits 7:0, is the threshold. A request is raised only when the winner's level is strictly greater than it.
- R8: A request also requires the winner's level to be strictly greater than the active level. The active level is 0 with nothing in service. An acknowledge during a request pushes the winner's level, which then becomes the active level.
- R9: A done pulse pops the in-service stack, and the active level returns to the level that was pushed before it.
- R10: `irq_tail` is high during a done pulse when a waiting winner's level is above both the threshold and the level that the pop restores.
- R11: After reset all registers read as 0 except the fixed control fill bits and the info word, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | Raw interrupt request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ID_W+1 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | ID_W | Winning source ID |
| irq_lvl | output | 8 | Winning source level |
| irq_ack | input | 1 | Core accepted the current request |
| irq_done | input | 1 | Core finished the current handler |
| irq_tail | output | 1 | Hand over directly to the waiting request |

## Verification
Suppose the in-service stack holds a wrong entry. A wrong push shows on the ports in the cycle after the acknowledge: a lower source that should stay masked gets a request. A wrong pop shows in the cycle after the done, when the restored threshold admits or blocks the wrong work, and in `irq_tail` during the done cycle itself. A stuck or wrongly cleared edge pending bit shows in the pending bit read back over the bus and in `irq_id` one cycle after the acknowledge. A ranking error shows at once in `irq_id` whenever two eligible sources compete.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  typedef enum logic [1:0] {
    TRG_HIGH = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_LOW  = 2'd3
  } trig_e;

  localparam logic [7:0] HW_VERSION = 8'h01;
endpackage

// File: rtl/cirq_src_gate.sv
module cirq_src_gate
  import cirq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ID_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      src_i,
  input  logic [NUM_SRC-1:0][1:0] trig_i,
  input  logic [NUM_SRC-1:0]      wr_i,
  input  logic                    wr_val_i,
  input  logic                    ack_i,
  input  logic [ID_W-1:0]         ack_id_i,
  output logic [NUM_SRC-1:0]      pend_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic  s1_q, s2_q, s3_q;
    logic  pend_q, pend_d;
    logic  edge_hit, is_edge, ack_hit;
    trig_e mode;

    assign mode    = trig_e'(trig_i[g]);
    assign is_edge = (mode == TRG_RISE) || (mode == TRG_FALL);
    assign ack_hit = ack_i && (ack_id_i == ID_W'(g));

    always_comb begin
      case (mode)
        TRG_RISE: edge_hit = s2_q & ~s3_q;
        TRG_FALL: edge_hit = ~s2_q & s3_q;
        default:  edge_hit = 1'b0;
      endcase
    end

    always_comb begin
      pend_d = pend_q;
      if (!is_edge)      pend_d = 1'b0;
      else if (edge_hit) pend_d = 1'b1;
      else if (ack_hit)  pend_d = 1'b0;
      else if (wr_i[g])  pend_d = wr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        s3_q   <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        s1_q   <= src_i[g];
        s2_q   <= s1_q;
        s3_q   <= s2_q;
        pend_q <= pend_d;
      end
    end

    assign pend_o[g] = is_edge ? pend_q : ((mode == TRG_LOW) ? ~s2_q : s2_q);

    // R3: an acknowledge with no new edge leaves the latched flag clear
    p_ack_clears_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && is_edge && !edge_hit) |=> !pend_q);
  end

endmodule

// File: rtl/cirq_arbiter.sv
module cirq_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC-1:0]      elig_i,
  input  logic [NUM_SRC-1:0][7:0] key_i,
  output logic                    valid_o,
  output logic [ID_W-1:0]         id_o,
  output logic [7:0]              key_o
);

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    key_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!valid_o || key_i[i] >= key_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        key_o   = key_i[i];
      end
    end
  end

endmodule

// File: rtl/cirq_lvl_stack.sv
module cirq_lvl_stack #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic [7:0] push_lvl_i,
  input  logic       pop_i,
  output logic [7:0] top_lvl_o,
  output logic [7:0] below_lvl_o,
  output logic       empty_o
);

  localparam int CNT_W = $clog2(DEPTH + 2);

  logic [DEPTH-1:0][7:0] stk_q, stk_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  stk_en;

  assign empty_o = (cnt_q == '0);

  always_comb begin
    top_lvl_o   = '0;
    below_lvl_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i + 1) == cnt_q) top_lvl_o   = stk_q[i];
      if (CNT_W'(i + 2) == cnt_q) below_lvl_o = stk_q[i];
    end
  end

  always_comb begin
    stk_d  = stk_q;
    cnt_d  = cnt_q;
    stk_en = 1'b0;
    if (push_i && (cnt_q < CNT_W'(DEPTH))) begin
      stk_en = 1'b1;
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) == cnt_q) stk_d[i] = push_lvl_i;
      cnt_d = cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stk_q <= '0;
    else if (stk_en) stk_q <= stk_d;
  end

  // R8: nesting only ever stacks a strictly higher level
  p_push_above_top_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !empty_o) |-> (push_lvl_i > top_lvl_o));

  // R9: leaving a handler brings back the level underneath
  p_pop_restores_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> (top_lvl_o == $past(below_lvl_o)));

endmodule

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl
  import cirq_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int CTL_BITS = 3,
  parameter int ID_W     = $clog2(NUM_SRC),
  parameter int ADDR_W   = ID_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic [7:0]         irq_lvl,
  input  logic               irq_ack,
  input  logic               irq_done,
  output logic               irq_tail
);

  localparam int FILL  = 8 - CTL_BITS;
  localparam int DEPTH = 1 << CTL_BITS;
  localparam logic [3:0] NL_MAX = 4'(CTL_BITS);
  localparam logic [31:0] INFO_WORD = 32'(HW_VERSION) | (32'(NUM_SRC) << 8)
                                    | (32'(CTL_BITS) << 21);

  // register state
  logic [NUM_SRC-1:0]               en_q, en_d;
  logic [NUM_SRC-1:0][1:0]          trig_q, trig_d;
  logic [NUM_SRC-1:0][CTL_BITS-1:0] ctl_q, ctl_d;
  logic [3:0]                       nl_q, nl_d;
  logic [7:0]                       thr_q, thr_d;

  logic                       wr_any, src_region;
  logic [NUM_SRC-1:0]         src_we;
  logic [NUM_SRC-1:0]         pend;
  logic [NUM_SRC-1:0][7:0]    ctl_full;
  logic [7:0]                 lvl_mask;
  logic                       win_valid;
  logic [ID_W-1:0]            win_id;
  logic [7:0]                 win_key, win_lvl;
  logic                       ack_eff, pop_eff;
  logic [7:0]                 act_lvl, below_lvl;
  logic                       stk_empty;
  logic                       wdata_unused;

  assign wdata_unused = ^{bus_wdata[31:16], bus_wdata[15-CTL_BITS:4]};

  assign wr_any     = bus_sel && bus_we;
  assign src_region = bus_addr[ADDR_W-1];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    assign src_we[g] = wr_any && src_region && (bus_addr[ID_W-1:0] == ID_W'(g));
    if (FILL > 0) begin : g_fill
      assign ctl_full[g] = {ctl_q[g], {FILL{1'b1}}};
    end else begin : g_nofill
      assign ctl_full[g] = ctl_q[g];
    end
  end

  // next-state for the register file
  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    ctl_d  = ctl_q;
    nl_d   = nl_q;
    thr_d  = thr_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_we[i]) begin
        en_d[i]   = bus_wdata[1];
        trig_d[i] = bus_wdata[3:2];
        ctl_d[i]  = bus_wdata[15:16-CTL_BITS];
      end
    end
    if (wr_any && !src_region) begin
      if (bus_addr[ID_W-1:0] == ID_W'(0))
        nl_d = (bus_wdata[3:0] > NL_MAX) ? NL_MAX : bus_wdata[3:0];
      if (bus_addr[ID_W-1:0] == ID_W'(2))
        thr_d = bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      trig_q <= '0;
      ctl_q  <= '0;
      nl_q   <= '0;
      thr_q  <= '0;
    end else if (wr_any) begin
      en_q   <= en_d;
      trig_q <= trig_d;
      ctl_q  <= ctl_d;
      nl_q   <= nl_d;
      thr_q  <= thr_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (src_region) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (bus_addr[ID_W-1:0] == ID_W'(i))
          bus_rdata = {16'b0, ctl_full[i], 4'b0, trig_q[i], en_q[i], pend[i]};
      end
    end else begin
      case (bus_addr[ID_W-1:0])
        ID_W'(0): bus_rdata = {28'b0, nl_q};
        ID_W'(1): bus_rdata = INFO_WORD;
        ID_W'(2): bus_rdata = {24'b0, thr_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  cirq_src_gate #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) i_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (irq_src),
    .trig_i   (trig_q),
    .wr_i     (src_we),
    .wr_val_i (bus_wdata[0]),
    .ack_i    (ack_eff),
    .ack_id_i (win_id),
    .pend_o   (pend)
  );

  cirq_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) i_arb (
    .elig_i  (pend & en_q),
    .key_i   (ctl_full),
    .valid_o (win_valid),
    .id_o    (win_id),
    .key_o   (win_key)
  );

  assign lvl_mask = 8'hFF >> nl_q;
  assign win_lvl  = win_key | lvl_mask;

  cirq_lvl_stack #(.DEPTH(DEPTH)) i_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (ack_eff),
    .push_lvl_i  (win_lvl),
    .pop_i       (pop_eff),
    .top_lvl_o   (act_lvl),
    .below_lvl_o (below_lvl),
    .empty_o     (stk_empty)
  );

  assign irq_req  = win_valid && (win_lvl > thr_q) && (win_lvl > act_lvl);
  assign irq_id   = win_id;
  assign irq_lvl  = win_lvl;
  assign ack_eff  = irq_ack && irq_req && !irq_done;
  assign pop_eff  = irq_done && !stk_empty;
  assign irq_tail = pop_eff && win_valid && (win_lvl > thr_q) && (win_lvl > below_lvl);

  // R4: the stored level-bit count never exceeds the implemented width
  p_nl_clamp_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    nl_q <= NL_MAX);

  // R6: the arbiter only names a source that is both pending and enabled
  p_win_eligible_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend[win_id] && en_q[win_id]));

  // R8: an accepted request becomes the active level one cycle later
  p_ack_sets_active_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    ack_eff |=> (act_lvl == $past(win_lvl)));

endmodule

// File: tb/test_core_irq_ctrl.sv
module test_core_irq_ctrl;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_src;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          irq_req, irq_ack, irq_done, irq_tail;
  logic [IW-1:0] irq_id;
  logic [7:0]    irq_lvl;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  core_irq_ctrl #(.NUM_SRC(N), .CTL_BITS(3)) i_core_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_id(irq_id), .irq_lvl(irq_lvl),
    .irq_ack(irq_ack), .irq_done(irq_done), .irq_tail(irq_tail)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [AW-1:0] sa(input int id);
    return AW'(16 + id);
  endfunction

  function automatic logic [31:0] sw(input bit en, input int trig, input int c);
    return (32'(c) << 13) | (32'(trig) << 2) | (32'(en) << 1);
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    irq_src = '0;
    for (int i = 0; i < N; i++) wr(sa(i), 32'h0);
    wr(AW'(2), 32'h0);
    wr(AW'(0), 32'h3);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq_req == 1'b0, "R11 req after reset", 32'(irq_req), 0);
    rd(AW'(0), d); chk(d == 0, "R11 cfg after reset", d, 0);
    rd(AW'(2), d); chk(d == 0, "R11 threshold after reset", d, 0);
    rd(sa(0), d);  chk(d == 32'h1F00, "R11 source word after reset", d, 32'h1F00);
  endtask

  task automatic t_info();
    logic [31:0] d;
    rd(AW'(1), d); chk(d == 32'h0060_1001, "R5 info value", d, 32'h0060_1001);
    wr(AW'(1), 32'h0);
    rd(AW'(1), d); chk(d == 32'h0060_1001, "R5 info write ignored", d, 32'h0060_1001);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(AW'(0), 32'h9); rd(AW'(0), d); chk(d == 3, "R4 clamp level bits", d, 3);
    wr(AW'(0), 32'h2); rd(AW'(0), d); chk(d == 2, "R4 level bits store", d, 2);
    wr(AW'(0), 32'h3);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(sa(4), sw(1, 1, 5));
    rd(sa(4), d); chk(d == 32'hBF06, "R1 source word layout", d, 32'hBF06);
    wr(sa(6), sw(1, 0, 2) | 32'h1);
    rd(sa(6), d); chk(d[0] == 1'b0, "R2 pending write ignored in level mode", 32'(d[0]), 0);
    wr(sa(4), 0); wr(sa(6), 0);
  endtask

  task automatic t_level();
    wr(sa(3), sw(1, 0, 2));
    irq_src[3] = 1'b1; settle();
    chk(irq_req && irq_id == 3 && irq_lvl == 8'h5F, "R2 level-high request",
        {irq_req, 15'b0, 4'(irq_id), 4'b0, irq_lvl}, {1'b1, 15'b0, 4'd3, 4'b0, 8'h5F});
    wr(sa(3), sw(1, 3, 2)); @(negedge clk);
    chk(irq_req == 1'b0, "R2 level-low idle while input high", 32'(irq_req), 0);
    irq_src[3] = 1'b0; settle();
    chk(irq_req && irq_id == 3, "R2 level-low request", 32'(irq_req), 1);
    clear_all();
    chk(irq_req == 1'b0, "R2 level-high drop", 32'(irq_req), 0);
  endtask

  task automatic t_arb();
    wr(sa(5), sw(1, 0, 2)); wr(sa(9), sw(1, 0, 2));
    irq_src[5] = 1'b1; irq_src[9] = 1'b1; settle();
    chk(irq_id == 9, "R6 tie goes to larger id", 32'(irq_id), 9);
    wr(sa(4), sw(1, 0, 4)); irq_src[4] = 1'b1; settle();
    chk(irq_id == 4 && irq_lvl == 8'h9F, "R6 higher level wins",
        {16'(irq_id), 8'b0, irq_lvl}, {16'd4, 8'b0, 8'h9F});
    wr(AW'(0), 32'h1); wr(sa(9), sw(1, 0, 6)); @(negedge clk);
    chk(irq_id == 9 && irq_lvl == 8'hFF, "R4 R6 same level, priority decides",
        {16'(irq_id), 8'b0, irq_lvl}, {16'd9, 8'b0, 8'hFF});
    wr(AW'(0), 32'h0); @(negedge clk);
    chk(irq_lvl == 8'hFF, "R4 zero level bits gives 255", 32'(irq_lvl), 32'hFF);
    clear_all();
  endtask

  task automatic t_thr();
    wr(sa(5), sw(1, 0, 2)); irq_src[5] = 1'b1;
    wr(AW'(2), 32'h5F); settle();
    chk(irq_req == 1'b0, "R7 level equal to threshold masked", 32'(irq_req), 0);
    wr(AW'(2), 32'h5E); @(negedge clk);
    chk(irq_req == 1'b1, "R7 level above threshold passes", 32'(irq_req), 1);
    clear_all();
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(sa(7), sw(1, 1, 3)); wr(sa(8), sw(1, 2, 1));
    irq_src[7] = 1'b1; @(negedge clk); irq_src[7] = 1'b0; settle();
    chk(irq_req && irq_id == 7 && irq_lvl == 8'h7F, "R3 rising edge latched",
        {16'(irq_id), 8'b0, irq_lvl}, {16'd7, 8'b0, 8'h7F});
    rd(sa(7), d); chk(d[0] == 1'b1, "R3 pending held after pulse", 32'(d[0]), 1);
    irq_src[8] = 1'b1; settle();
    rd(sa(8), d); chk(d[0] == 1'b0, "R3 falling source ignores rise", 32'(d[0]), 0);
    irq_src[8] = 1'b0; settle();
    rd(sa(8), d); chk(d[0] == 1'b1, "R3 falling edge latched", 32'(d[0]), 1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(irq_req == 1'b0, "R8 lower level blocked while serviced", 32'(irq_req), 0);
    rd(sa(7), d); chk(d[0] == 1'b0, "R3 ack clears pending", 32'(d[0]), 0);
    wr(sa(2), sw(1, 0, 5)); irq_src[2] = 1'b1; settle();
    chk(irq_req && irq_id == 2, "R8 higher level preempts", 32'(irq_id), 2);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(irq_req == 1'b0, "R8 same level does not preempt itself", 32'(irq_req), 0);
    irq_src[2] = 1'b0; settle();
    @(negedge clk); irq_done = 1'b1; #1;
    chk(irq_tail == 1'b0, "R10 no tail when restored level is higher", 32'(irq_tail), 0);
    @(negedge clk); irq_done = 1'b0;
    chk(irq_req == 1'b0, "R9 restored level still masks", 32'(irq_req), 0);
    @(negedge clk); irq_done = 1'b1; #1;
    chk(irq_tail == 1'b1, "R10 tail-chain on exit", 32'(irq_tail), 1);
    @(negedge clk); irq_done = 1'b0;
    chk(irq_req && irq_id == 8, "R9 R10 waiting source requested after exit",
        {31'b0, irq_req} | (32'(irq_id) << 8), 32'h0801);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    @(negedge clk); irq_done = 1'b1; @(negedge clk); irq_done = 1'b0;
    chk(irq_req == 1'b0, "R3 ack cleared falling source", 32'(irq_req), 0);
    wr(sa(8), sw(1, 2, 1) | 32'h1); @(negedge clk);
    chk(irq_req && irq_id == 8, "R3 bus write sets pending", 32'(irq_req), 1);
    wr(sa(8), sw(1, 2, 1)); @(negedge clk);
    chk(irq_req == 1'b0, "R3 bus write clears pending", 32'(irq_req), 0);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; irq_src = '0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; irq_ack = 1'b0; irq_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_info();
    t_cfg();
    t_regs();
    t_level();
    t_arb();
    t_thr();
    t_nest();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; misses++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule